// File: doc/BRIEF.md
# Memory Access Footprint Decomposer

This block sits between an instruction's memory access request and the memory ordering logic. It takes one request (address, log2 byte size, load/store flag and an access kind tag) and breaks it into the architecturally atomic operations that the rest of the machine tracks. An access aligned to its own size becomes a single operation. A misaligned access becomes one single-byte operation per byte. Operations leave one per cycle over a valid/ready handshake, lowest address first. Each one carries its address, its log2 byte count, a byte-lane mask within a `2**MAX_LG`-byte word and a flag marking the last operation of the request.

Stores run in two phases. The footprint phase emits the store's operations with no value. The store is then held, without data, in a single store slot. While it waits there, a query port tells younger accesses whether their byte range overlaps it. Later, the data phase takes the store value on a separate handshake. It spreads the value's bytes over the same operations, in the same address order, and emits them on a data-operation stream with lane-aligned data. A value that arrives while no store is held is consumed, dropped and reported.

Top module: `fpd_decomposer`

## Requirements
- R1: After reset, `op_valid`, `wop_valid`, `err_orphan` and `chk_hit` are 0, and `req_ready` and `dat_ready` are 1.
- R2: A request whose address is a multiple of `2**req_lg` produces exactly one operation with `op_addr` equal to the request address, `op_lg` equal to `req_lg` and `op_last` = 1. `req_lg` never exceeds `MAX_LG`.
- R3: A request whose address is not a multiple of `2**req_lg` produces `2**req_lg` operations with `op_lg` = 0, at addresses `addr`, `addr+1`, … `addr+2**req_lg-1` in that order. `op_last` is 1 on the final operation only.
- R4: `op_mask` (and `wop_mask`) has bit `(op_addr mod 2**MAX_LG) + j` set for `j` = 0 … `2**op_lg-1`, and no other bit set.
- R5: While `op_valid` is 1 and `op_ready` is 0, the offered operation does not change. `req_ready` stays 0 from the acceptance of a request until its last operation is accepted.
- R6: Once the last footprint operation of a store is accepted, `dat_ready` is 1, and the next `dat_valid` is taken as that store's value.
- R7: The data phase emits the same sequence of addresses, `wop_lg`, masks and `wop_last` flags as the store's footprint. Value byte `k` (bits `8k+7:8k`) is placed for address `base+k` in byte lane `(base+k) mod 2**MAX_LG` of `wop_data`. All other lanes are zero, so value bytes beyond the store size have no effect.
- R8: A `dat_valid` while no store is held is accepted (`dat_ready` = 1) and dropped. `err_orphan` is 1 for exactly the following cycle, no data operation results, and a later store still uses its own value.
- R9: `dat_ready` is 0 while a store's footprint operations are still being emitted and while its data operations are being emitted.
- R10: With `CHK_PIPE` = 0, `chk_hit` is 1 exactly when a store is held without data (footprint in progress or awaiting data) and the byte range `[chk_addr, chk_addr+2**chk_lg)` overlaps the store's range `[base, base+2**lg)`.
- R11: While a store is held in the slot, a store request sees `req_ready` = 0, while a load request can still be accepted.
- R12: `op_store` and `op_kind` on every operation equal the flag and kind of the request it came from.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request accepted this cycle when valid |
| req_addr | input | ADDR_W | Byte address of the access |
| req_lg | input | SZ_W | log2 of the access size in bytes |
| req_store | input | 1 | 1 for a store, 0 for a load |
| req_kind | input | KIND_W | Opaque access kind, passed through |
| op_valid | output | 1 | Footprint operation offered |
| op_ready | input | 1 | Footprint operation taken |
| op_addr | output | ADDR_W | Operation address |
| op_lg | output | SZ_W | log2 of operation byte count |
| op_mask | output | MAX_B | Byte lanes covered by the operation |
| op_store | output | 1 | Operation belongs to a store |
| op_kind | output | KIND_W | Kind of the originating request |
| op_last | output | 1 | Final operation of the request |
| dat_valid | input | 1 | Store value offered |
| dat_ready | output | 1 | Store value accepted |
| dat_value | input | 8*MAX_B | Store value, byte 0 at the lowest address |
| wop_valid | output | 1 | Data operation offered |
| wop_ready | input | 1 | Data operation taken |
| wop_addr | output | ADDR_W | Data operation address |
| wop_lg | output | SZ_W | log2 of data operation byte count |
| wop_mask | output | MAX_B | Byte lanes written |
| wop_data | output | 8*MAX_B | Lane-aligned store bytes |
| wop_last | output | 1 | Final data operation of the store |
| chk_addr | input | ADDR_W | Overlap query address |
| chk_lg | input | SZ_W | log2 of the overlap query size |
| chk_hit | output | 1 | Query overlaps the held store |
| err_orphan | output | 1 | Store value arrived with no held store |

## Verification
The assertions check the per-cycle rules on every clock. An offer under back-pressure stays stable. The address steps by one after each accepted non-final operation. Every operation after the first is a single byte, and the popcount of each mask matches its byte count. No value is taken while a store's footprint is still being offered. An orphan value is never followed by a data operation, and no overlap hit is raised while data operations are being emitted. Only the bench scenarios can show the exact addresses, lane masks and lane placement of each value byte across a lane wrap. They also cover the blocking of a second store while a load passes, the overlap answers at the edges of the held range, and that a dropped value does not leak into the next store.

// File: rtl/fpd_pkg.sv
package fpd_pkg;

   // Largest supported log2 word width (lane mask fits in 64 bits).
   localparam int unsigned FPD_LIM_LG = 6;

   typedef enum logic [1:0] {
      SL_EMPTY = 2'd0,   // no store held
      SL_ANNC  = 2'd1,   // footprint operations being emitted
      SL_WAIT  = 2'd2,   // footprint done, value not yet received
      SL_DRAIN = 2'd3    // value being spread over data operations
   } fpd_slot_e;

   // Byte lanes covered by 2**lg bytes starting at lane lo.
   function automatic logic [63:0] fpd_lane_mask(input logic [5:0] lo, input logic [2:0] lg);
      logic [63:0] m;
      if (lg >= 3'd6) m = '1;
      else            m = (64'd1 << (7'd1 << lg)) - 64'd1;
      return m << lo;
   endfunction

endpackage

// File: rtl/fpd_walk.sv
// Walks the atomic operations of one access: one operation for an aligned
// access, otherwise one byte per step in ascending address order.
module fpd_walk #(
   parameter  int unsigned ADDR_W = 32,
   parameter  int unsigned MAX_LG = 3,
   localparam int unsigned SZ_W   = $clog2(MAX_LG + 1),
   localparam int unsigned CNT_W  = MAX_LG + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [ADDR_W-1:0] st_addr,
   input  logic [SZ_W-1:0]   st_lg,
   input  logic              ready,
   output logic              busy,
   output logic [ADDR_W-1:0] cur_addr,
   output logic [SZ_W-1:0]   cur_lg,
   output logic [MAX_LG-1:0] idx,
   output logic              last
);

   logic [MAX_LG-1:0] off;
   logic [MAX_LG-1:0] lo_mask;
   logic [CNT_W-1:0]  span;
   logic              aligned;
   logic [CNT_W-1:0]  rem_q;

   always_comb begin
      off     = st_addr[MAX_LG-1:0];
      span    = CNT_W'(1) << st_lg;
      lo_mask = span[MAX_LG-1:0] - MAX_LG'(1);
      aligned = (off & lo_mask) == '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy     <= 1'b0;
         cur_addr <= '0;
         cur_lg   <= '0;
         idx      <= '0;
         rem_q    <= '0;
      end else if (start) begin
         busy     <= 1'b1;
         cur_addr <= st_addr;
         idx      <= '0;
         if (aligned) begin
            cur_lg <= st_lg;
            rem_q  <= CNT_W'(1);
         end else begin
            cur_lg <= '0;
            rem_q  <= span;
         end
      end else if (busy && ready) begin
         if (last) begin
            busy <= 1'b0;
         end else begin
            cur_addr <= cur_addr + ADDR_W'(1);
            idx      <= idx + MAX_LG'(1);
            rem_q    <= rem_q - CNT_W'(1);
         end
      end
   end

   assign last = (rem_q == CNT_W'(1));

   AST_START_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      start |-> !busy) else $error("walker restarted while busy"); // R5

endmodule

// File: rtl/fpd_slot.sv
// Single store slot: holds a store's footprint from request to value,
// answers overlap queries and captures the value for the data phase.
module fpd_slot
   import fpd_pkg::*;
#(
   parameter  int unsigned ADDR_W   = 32,
   parameter  int unsigned MAX_LG   = 3,
   parameter  int unsigned CHK_PIPE = 0,
   localparam int unsigned SZ_W     = $clog2(MAX_LG + 1),
   localparam int unsigned DW       = 8 << MAX_LG,
   localparam int unsigned AW1      = ADDR_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              st_fire,
   input  logic [ADDR_W-1:0] st_addr,
   input  logic [SZ_W-1:0]   st_lg,
   input  logic              fp_done,
   input  logic              dat_valid,
   input  logic [DW-1:0]     dat_value,
   output logic              dat_ready,
   output logic              drain_start,
   input  logic              drain_done,
   output logic              busy,
   output logic [ADDR_W-1:0] base_addr,
   output logic [SZ_W-1:0]   base_lg,
   output logic [DW-1:0]     value,
   output logic              err_orphan,
   input  logic [ADDR_W-1:0] chk_addr,
   input  logic [SZ_W-1:0]   chk_lg,
   output logic              chk_hit
);

   fpd_slot_e state_q;
   logic      held;
   logic      raw_hit;
   logic [AW1-1:0] s_lo, s_hi, c_lo, c_hi;

   always_comb begin
      dat_ready   = (state_q == SL_EMPTY) || (state_q == SL_WAIT);
      drain_start = dat_valid && (state_q == SL_WAIT);
      busy        = (state_q != SL_EMPTY);
      held        = (state_q == SL_ANNC) || (state_q == SL_WAIT);
      s_lo        = {1'b0, base_addr};
      s_hi        = s_lo + (AW1'(1) << base_lg);
      c_lo        = {1'b0, chk_addr};
      c_hi        = c_lo + (AW1'(1) << chk_lg);
      raw_hit     = held && (c_lo < s_hi) && (s_lo < c_hi);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= SL_EMPTY;
         base_addr  <= '0;
         base_lg    <= '0;
         value      <= '0;
         err_orphan <= 1'b0;
      end else begin
         err_orphan <= dat_valid && (state_q == SL_EMPTY);
         case (state_q)
            SL_EMPTY: if (st_fire) begin
               state_q   <= SL_ANNC;
               base_addr <= st_addr;
               base_lg   <= st_lg;
            end
            SL_ANNC:  if (fp_done) state_q <= SL_WAIT;
            SL_WAIT:  if (dat_valid) begin
               value   <= dat_value;
               state_q <= SL_DRAIN;
            end
            SL_DRAIN: if (drain_done) state_q <= SL_EMPTY;
            default:  state_q <= SL_EMPTY;
         endcase
      end
   end

   generate
      if (CHK_PIPE == 0) begin : g_chk_comb
         assign chk_hit = raw_hit;
      end else begin : g_chk_reg
         logic hit_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) hit_q <= 1'b0;
            else        hit_q <= raw_hit;
         end
         assign chk_hit = hit_q;
      end
   endgenerate

   AST_FILL_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      st_fire |-> state_q == SL_EMPTY) else $error("store accepted into full slot"); // R11
   AST_DONE_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
      drain_done |-> state_q == SL_DRAIN) else $error("data ended outside drain"); // R7
   AST_FP_ANNC: assert property (@(posedge clk) disable iff (!rst_n)
      fp_done |-> state_q == SL_ANNC) else $error("footprint end without store"); // R6

endmodule

// File: rtl/fpd_decomposer.sv
// Splits memory accesses into atomic operations; stores are announced
// first and receive their value in a later data phase.
module fpd_decomposer
   import fpd_pkg::*;
#(
   parameter  int unsigned ADDR_W   = 32,
   parameter  int unsigned MAX_LG   = 3,
   parameter  int unsigned KIND_W   = 3,
   parameter  int unsigned CHK_PIPE = 0,
   localparam int unsigned SZ_W     = $clog2(MAX_LG + 1),
   localparam int unsigned MAX_B    = 1 << MAX_LG,
   localparam int unsigned DW       = 8 * MAX_B
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [SZ_W-1:0]   req_lg,
   input  logic              req_store,
   input  logic [KIND_W-1:0] req_kind,
   output logic              op_valid,
   input  logic              op_ready,
   output logic [ADDR_W-1:0] op_addr,
   output logic [SZ_W-1:0]   op_lg,
   output logic [MAX_B-1:0]  op_mask,
   output logic              op_store,
   output logic [KIND_W-1:0] op_kind,
   output logic              op_last,
   input  logic              dat_valid,
   output logic              dat_ready,
   input  logic [DW-1:0]     dat_value,
   output logic              wop_valid,
   input  logic              wop_ready,
   output logic [ADDR_W-1:0] wop_addr,
   output logic [SZ_W-1:0]   wop_lg,
   output logic [MAX_B-1:0]  wop_mask,
   output logic [DW-1:0]     wop_data,
   output logic              wop_last,
   input  logic [ADDR_W-1:0] chk_addr,
   input  logic [SZ_W-1:0]   chk_lg,
   output logic              chk_hit,
   output logic              err_orphan
);

   generate
      if (MAX_LG < 1 || MAX_LG > FPD_LIM_LG) begin : g_bad_lg
         $error("MAX_LG out of supported range");
      end
      if (ADDR_W <= MAX_LG) begin : g_bad_aw
         $error("ADDR_W must exceed MAX_LG");
      end
      if (CHK_PIPE > 1) begin : g_bad_pipe
         $error("CHK_PIPE must be 0 or 1");
      end
   endgenerate

   logic              req_fire;
   logic              slot_busy;
   logic              fp_done;
   logic              drain_start;
   logic              drain_done;
   logic [ADDR_W-1:0] base_addr;
   logic [SZ_W-1:0]   base_lg;
   logic [DW-1:0]     slot_value;
   logic [MAX_LG-1:0] fw_idx;
   logic [MAX_LG-1:0] d_idx;
   logic [DW-1:0]     shifted;
   logic [DW-1:0]     placed;
   logic [DW-1:0]     byte_en;

   assign req_ready = !op_valid && !(req_store && slot_busy);
   assign req_fire  = req_valid && req_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         op_store <= 1'b0;
         op_kind  <= '0;
      end else if (req_fire) begin
         op_store <= req_store;
         op_kind  <= req_kind;
      end
   end

   fpd_walk #(.ADDR_W(ADDR_W), .MAX_LG(MAX_LG)) i_fp_walk (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (req_fire),
      .st_addr  (req_addr),
      .st_lg    (req_lg),
      .ready    (op_ready),
      .busy     (op_valid),
      .cur_addr (op_addr),
      .cur_lg   (op_lg),
      .idx      (fw_idx),
      .last     (op_last)
   );

   assign op_mask = MAX_B'(fpd_lane_mask(6'(op_addr[MAX_LG-1:0]), 3'(op_lg)));
   assign fp_done = op_valid && op_ready && op_last && op_store;

   fpd_slot #(.ADDR_W(ADDR_W), .MAX_LG(MAX_LG), .CHK_PIPE(CHK_PIPE)) i_slot (
      .clk         (clk),
      .rst_n       (rst_n),
      .st_fire     (req_fire && req_store),
      .st_addr     (req_addr),
      .st_lg       (req_lg),
      .fp_done     (fp_done),
      .dat_valid   (dat_valid),
      .dat_value   (dat_value),
      .dat_ready   (dat_ready),
      .drain_start (drain_start),
      .drain_done  (drain_done),
      .busy        (slot_busy),
      .base_addr   (base_addr),
      .base_lg     (base_lg),
      .value       (slot_value),
      .err_orphan  (err_orphan),
      .chk_addr    (chk_addr),
      .chk_lg      (chk_lg),
      .chk_hit     (chk_hit)
   );

   fpd_walk #(.ADDR_W(ADDR_W), .MAX_LG(MAX_LG)) i_dat_walk (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (drain_start),
      .st_addr  (base_addr),
      .st_lg    (base_lg),
      .ready    (wop_ready),
      .busy     (wop_valid),
      .cur_addr (wop_addr),
      .cur_lg   (wop_lg),
      .idx      (d_idx),
      .last     (wop_last)
   );

   assign wop_mask   = MAX_B'(fpd_lane_mask(6'(wop_addr[MAX_LG-1:0]), 3'(wop_lg)));
   assign drain_done = wop_valid && wop_ready && wop_last;

   for (genvar b = 0; b < MAX_B; b++) begin : g_lane
      assign byte_en[8*b +: 8] = {8{wop_mask[b]}};
   end

   always_comb begin
      shifted  = slot_value >> {d_idx, 3'b000};
      placed   = shifted << {wop_addr[MAX_LG-1:0], 3'b000};
      wop_data = placed & byte_en;
   end

   AST_LG_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> int'(req_lg) <= int'(MAX_LG)) else $error("size beyond word"); // R2
   AST_REQ_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_ready |=> op_valid) else $error("request produced no op"); // R2
   AST_OP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      op_valid && !op_ready |=> op_valid && $stable(op_addr) && $stable(op_mask)) else $error("op changed under stall"); // R5
   AST_ASCEND: assert property (@(posedge clk) disable iff (!rst_n)
      op_valid && op_ready && !op_last |=> op_valid && (op_addr == $past(op_addr) + ADDR_W'(1))) else $error("ops not ascending"); // R3
   AST_TAIL_BYTES: assert property (@(posedge clk) disable iff (!rst_n)
      op_valid && (fw_idx != '0) |-> op_lg == '0) else $error("split op wider than a byte"); // R3
   AST_MASK_SIZE: assert property (@(posedge clk) disable iff (!rst_n)
      op_valid |-> $countones(op_mask) == (1 << op_lg)) else $error("mask popcount"); // R4
   AST_WOP_MASK_SIZE: assert property (@(posedge clk) disable iff (!rst_n)
      wop_valid |-> $countones(wop_mask) == (1 << wop_lg)) else $error("data mask popcount"); // R7
   AST_NO_EARLY_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      dat_valid && dat_ready |-> !(op_valid && op_store)) else $error("value before footprint"); // R9
   AST_ORPHAN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      err_orphan |-> !wop_valid) else $error("orphan value emitted"); // R8

   generate
      if (CHK_PIPE == 0) begin : g_chk_ast
         AST_NO_HIT_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
            wop_valid |-> !chk_hit) else $error("hit while draining"); // R10
      end
   endgenerate

endmodule

// File: tb/test_fpd_decomposer.sv
`timescale 1ns/1ps
module test_fpd_decomposer;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [31:0] req_addr = '0;
   logic [1:0]  req_lg = '0;
   logic        req_store = 1'b0;
   logic [2:0]  req_kind = '0;
   logic        op_valid;
   logic        op_ready = 1'b1;
   logic [31:0] op_addr;
   logic [1:0]  op_lg;
   logic [7:0]  op_mask;
   logic        op_store;
   logic [2:0]  op_kind;
   logic        op_last;
   logic        dat_valid = 1'b0;
   logic        dat_ready;
   logic [63:0] dat_value = '0;
   logic        wop_valid;
   logic        wop_ready = 1'b1;
   logic [31:0] wop_addr;
   logic [1:0]  wop_lg;
   logic [7:0]  wop_mask;
   logic [63:0] wop_data;
   logic        wop_last;
   logic [31:0] chk_addr = '0;
   logic [1:0]  chk_lg = '0;
   logic        chk_hit;
   logic        err_orphan;

   int nchk = 0;
   int nfail = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   fpd_decomposer i_fpd_decomposer (.*);

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic cyc();
      @(posedge clk); #1;
   endtask

   function automatic logic [7:0] exp_mask(input logic [31:0] a, input int cnt);
      logic [63:0] m;
      m = ((64'd1 << cnt) - 64'd1) << a[2:0];
      return m[7:0];
   endfunction

   task automatic send_req(input logic [31:0] a, input int lg, input logic st, input logic [2:0] k);
      req_valid = 1'b1; req_addr = a; req_lg = 2'(lg); req_store = st; req_kind = k;
      #1;
      while (!req_ready) begin @(posedge clk); #1; end
      @(posedge clk); #1;
      req_valid = 1'b0;
   endtask

   task automatic send_dat(input logic [63:0] v);
      dat_valid = 1'b1; dat_value = v;
      #1;
      while (!dat_ready) begin @(posedge clk); #1; end
      @(posedge clk); #1;
      dat_valid = 1'b0;
   endtask

   task automatic expect_ops(input logic [31:0] a, input int lg, input logic st, input logic [2:0] k);
      int  sz = 1 << lg;
      bit  al = (a % sz) == 0;
      int  n = al ? 1 : sz;
      for (int i = 0; i < n; i++) begin
         logic [31:0] ea = al ? a : a + i;
         string tg = al ? "R2" : "R3";
         chk(tg, op_valid, 1'b1);
         chk(tg, op_addr, ea);
         chk(tg, op_lg, al ? lg : 0);
         chk("R3", op_last, i == n - 1);
         chk("R4", op_mask, exp_mask(ea, al ? sz : 1));
         chk("R12", {op_store, op_kind}, {st, k});
         cyc();
      end
      chk("R5", op_valid, 1'b0);
   endtask

   task automatic expect_wops(input logic [31:0] a, input int lg, input logic [63:0] v);
      int  sz = 1 << lg;
      bit  al = (a % sz) == 0;
      int  n = al ? 1 : sz;
      for (int i = 0; i < n; i++) begin
         logic [31:0] ea = al ? a : a + i;
         logic [63:0] ed;
         if (al) ed = ((sz == 8) ? v : (v & ((64'd1 << (8 * sz)) - 64'd1))) << (8 * ea[2:0]);
         else    ed = ((v >> (8 * i)) & 64'hFF) << (8 * ea[2:0]);
         chk("R7", wop_valid, 1'b1);
         chk("R7", wop_addr, ea);
         chk("R7", wop_lg, al ? lg : 0);
         chk("R7", wop_mask, exp_mask(ea, al ? sz : 1));
         chk("R7", wop_data, ed);
         chk("R7", wop_last, i == n - 1);
         chk("R9", dat_ready, 1'b0);
         cyc();
      end
      chk("R7", wop_valid, 1'b0);
   endtask

   task automatic probe(input logic [31:0] a, input int lg, input logic exp);
      chk_addr = a; chk_lg = 2'(lg);
      #1;
      chk("R10", chk_hit, exp);
      cyc();
   endtask

   task automatic t_reset();
      chk("R1", op_valid, 1'b0);
      chk("R1", wop_valid, 1'b0);
      chk("R1", err_orphan, 1'b0);
      chk("R1", chk_hit, 1'b0);
      chk("R1", req_ready, 1'b1);
      chk("R1", dat_ready, 1'b1);
   endtask

   task automatic t_aligned();
      send_req(32'h104, 2, 1'b0, 3'd5); expect_ops(32'h104, 2, 1'b0, 3'd5);
      send_req(32'h200, 3, 1'b0, 3'd1); expect_ops(32'h200, 3, 1'b0, 3'd1);
      send_req(32'h33,  0, 1'b0, 3'd7); expect_ops(32'h33,  0, 1'b0, 3'd7);
   endtask

   task automatic t_misaligned();
      send_req(32'h106, 2, 1'b0, 3'd2); expect_ops(32'h106, 2, 1'b0, 3'd2);
      send_req(32'h1FD, 3, 1'b0, 3'd0); expect_ops(32'h1FD, 3, 1'b0, 3'd0);
   endtask

   task automatic t_backpressure();
      op_ready = 1'b0;
      send_req(32'h301, 1, 1'b0, 3'd3);
      for (int i = 0; i < 3; i++) begin
         chk("R5", op_valid, 1'b1);
         chk("R5", op_addr, 32'h301);
         cyc();
      end
      req_valid = 1'b1; req_addr = 32'h400; req_lg = 2'd0; req_store = 1'b0;
      #1;
      chk("R5", req_ready, 1'b0);
      req_valid = 1'b0;
      cyc();
      op_ready = 1'b1;
      #1;
      expect_ops(32'h301, 1, 1'b0, 3'd3);
      chk("R5", req_ready, 1'b1);
   endtask

   task automatic t_store_split();
      logic [63:0] v = 64'h1122_3344_5566_BBAA;
      op_ready = 1'b0;
      send_req(32'h2F7, 1, 1'b1, 3'd4);
      chk("R9", dat_ready, 1'b0);
      probe(32'h2F8, 0, 1'b1);
      probe(32'h2F4, 2, 1'b1);
      probe(32'h2F0, 2, 1'b0);
      probe(32'h2F9, 0, 1'b0);
      probe(32'h2F6, 0, 1'b0);
      op_ready = 1'b1;
      #1;
      expect_ops(32'h2F7, 1, 1'b1, 3'd4);
      chk("R6", dat_ready, 1'b1);
      chk("R6", wop_valid, 1'b0);
      probe(32'h2F7, 0, 1'b1);
      send_req(32'h40, 0, 1'b0, 3'd1);
      expect_ops(32'h40, 0, 1'b0, 3'd1);
      req_valid = 1'b1; req_addr = 32'h500; req_lg = 2'd2; req_store = 1'b1;
      #1;
      chk("R11", req_ready, 1'b0);
      req_valid = 1'b0;
      cyc();
      chk_addr = 32'h2F7; chk_lg = 2'd0;
      send_dat(v);
      chk("R10", chk_hit, 1'b0);
      expect_wops(32'h2F7, 1, v);
      chk("R8", err_orphan, 1'b0);
      chk("R11", dat_ready, 1'b1);
   endtask

   task automatic t_store_aligned();
      send_req(32'h10, 2, 1'b1, 3'd6); expect_ops(32'h10, 2, 1'b1, 3'd6);
      send_dat(64'hDEAD_BEEF_1122_3344);
      expect_wops(32'h10, 2, 64'hDEAD_BEEF_1122_3344);
      send_req(32'h3D, 2, 1'b1, 3'd2); expect_ops(32'h3D, 2, 1'b1, 3'd2);
      send_dat(64'h0000_0000_A1B2_C3D4);
      expect_wops(32'h3D, 2, 64'h0000_0000_A1B2_C3D4);
   endtask

   task automatic t_orphan();
      chk("R8", dat_ready, 1'b1);
      send_dat(64'h77);
      chk("R8", err_orphan, 1'b1);
      chk("R8", wop_valid, 1'b0);
      cyc();
      chk("R8", err_orphan, 1'b0);
      chk("R8", wop_valid, 1'b0);
      send_req(32'h80, 0, 1'b1, 3'd0); expect_ops(32'h80, 0, 1'b1, 3'd0);
      chk("R8", wop_valid, 1'b0);
      send_dat(64'h5A);
      expect_wops(32'h80, 0, 64'h5A);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      cyc();
      t_reset();
      t_aligned();
      t_misaligned();
      t_backpressure();
      t_store_split();
      t_store_aligned();
      t_orphan();
      done = 1'b1;
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         nchk++;
         nfail++;
         $display("FAIL watchdog: run hung, actual=running expected=done");
         $display("%0d/%0d checks passed", nchk - nfail, nchk);
         $finish;
      end
   end

endmodule